// File: doc/BRIEF.md
# HI/LO Integer Multiply-Divide Unit

This unit carries out signed and unsigned multiplication and division on two operands of `WIDTH` bits, 32 by default, and places the results in a pair of result registers, HI and LO. A multiply stores the upper half of the double-width product in HI and the lower half in LO. A division stores the quotient in LO and the remainder in HI. Multiplies and the special-case divisions finish at the edge that accepts `start`. A regular division runs a restoring shift-subtract loop of one quotient bit per cycle. It then needs one more cycle to correct the signs, and `busy` is held high for that whole time.

Division never traps. A zero divisor gives fixed results, and so does the one signed quotient that cannot be represented. A new `start` is accepted in any cycle and discards a division that is still running. Move ports let software load HI or LO directly. Code that reads HI or LO waits until `busy` is low.

Top module: `hilo_muldiv`

## Requirements
- R1: With `op`=0 (signed multiply), both operands are sign-extended. At the edge that samples `start`, HI takes the upper `WIDTH` bits of their product and LO takes the lower `WIDTH` bits. `busy` stays low.
- R2: With `op`=1 (unsigned multiply), the operands are zero-extended and the product is split between HI and LO in the same way. `busy` stays low.
- R3: With `op`=2 (signed divide) and a normal operand pair, LO receives the quotient truncated toward zero. HI receives the remainder, which has the same sign as the dividend.
- R4: With `op`=3 (unsigned divide) and a nonzero divisor, LO receives the quotient and HI receives the remainder.
- R5: A signed divide by zero completes at the start edge. HI receives the dividend. LO receives all ones when the dividend is non-negative and 1 when it is negative.
- R6: An unsigned divide by zero completes at the start edge. HI receives the dividend and LO receives all ones.
- R7: A signed divide of the most negative value by -1 (all ones) completes at the start edge. LO receives the most negative value and HI receives zero.
- R8: A regular divide holds `busy` high for exactly `WIDTH`+1 cycles after the start edge. HI and LO keep their values during that time, and the results are present once `busy` falls.
- R9: A `start` that arrives while `busy` is high abandons the running divide. Only the new operation's results appear, and any new divide gets its full `WIDTH`+1 busy cycles.
- R10: `hi_wr` or `lo_wr` loads `wr_data` into HI or LO at the next edge. When `start` is high in the same cycle, the move is ignored and the new operation's result is kept.
- R11: After reset, HI and LO are zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the operation selected by `op` |
| op | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opa | input | WIDTH | Multiplicand or dividend |
| opb | input | WIDTH | Multiplier or divisor |
| hi_wr | input | 1 | Load `wr_data` into HI |
| lo_wr | input | 1 | Load `wr_data` into LO |
| wr_data | input | WIDTH | Data for the move ports |
| busy | output | 1 | A divide is in progress |
| hi | output | WIDTH | HI register |
| lo | output | WIDTH | LO register |

## Verification
A 5-bit instance is swept over every operand pair for all four operations. This exercises the sign correction for each combination of signs. A design that fixed the signs incorrectly would return a remainder with the divisor's sign, or a quotient rounded toward minus infinity.

The same sweep covers the zero divisor and the most-negative-by-minus-one case. An implementation that ran these through the iterative loop would return an unsigned-looking quotient, or stay busy when it should not.

A 32-bit instance is checked with directed extremes, with a restart in the middle of a division, and with a move issued together with `start`. A design that kept iterating after a restart would deliver stale results or the wrong busy length. A design that gave the move priority would lose the product.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
    typedef enum logic [1:0] {
        OP_SMUL = 2'd0,
        OP_UMUL = 2'd1,
        OP_SDIV = 2'd2,
        OP_UDIV = 2'd3
    } hilo_op_e;
endpackage

// File: rtl/hilo_mul.sv
// Single-cycle product; signedness chosen by one extension bit per operand.
module hilo_mul #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic               signed_i,
    output logic [2*WIDTH-1:0] prod
);
    localparam int EW = WIDTH + 1;
    localparam int PW = 2 * EW;

    logic [EW-1:0] ext_a, ext_b;
    logic [PW-1:0] full;

    assign ext_a = {signed_i & a[WIDTH-1], a};
    assign ext_b = {signed_i & b[WIDTH-1], b};
    // Low PW bits of the product are the same for signed or unsigned view.
    assign full  = {{EW{ext_a[EW-1]}}, ext_a} * {{EW{ext_b[EW-1]}}, ext_b};
    assign prod  = full[2*WIDTH-1:0];
endmodule

// File: rtl/hilo_div_step.sv
// One restoring shift-subtract step on unsigned magnitudes.
module hilo_div_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] den_i,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] quo_o
);
    logic [WIDTH:0] shifted;
    logic [WIDTH:0] diff;

    always_comb begin
        shifted = {rem_i, quo_i[WIDTH-1]};
        diff    = shifted - {1'b0, den_i};
        if (!diff[WIDTH]) begin
            rem_o = diff[WIDTH-1:0];
            quo_o = {quo_i[WIDTH-2:0], 1'b1};
        end else begin
            rem_o = shifted[WIDTH-1:0];
            quo_o = {quo_i[WIDTH-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
    import hilo_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             hi_wr,
    input  logic             lo_wr,
    input  logic [WIDTH-1:0] wr_data,
    output logic             busy,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);
    localparam int              CW       = $clog2(WIDTH + 1);
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] MIN_NEG  = {1'b1, {(WIDTH-1){1'b0}}};

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] den;
        logic             neg_q;
        logic             neg_r;
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
    } state_t;

    state_t st_q, st_d;

    hilo_op_e         op_e;
    logic             is_signed;
    logic             a_neg, b_neg;
    logic [WIDTH-1:0] a_mag, b_mag;
    logic [2*WIDTH-1:0] prod;
    logic [WIDTH-1:0] step_rem, step_quo;

    assign op_e      = hilo_op_e'(op);
    assign is_signed = (op_e == OP_SMUL) || (op_e == OP_SDIV);
    assign a_neg     = is_signed & opa[WIDTH-1];
    assign b_neg     = is_signed & opb[WIDTH-1];
    assign a_mag     = a_neg ? (~opa + ONE) : opa;
    assign b_mag     = b_neg ? (~opb + ONE) : opb;

    hilo_mul #(.WIDTH(WIDTH)) u_mul (
        .a        (opa),
        .b        (opb),
        .signed_i (is_signed),
        .prod     (prod)
    );

    hilo_div_step #(.WIDTH(WIDTH)) u_step (
        .rem_i (st_q.rem),
        .quo_i (st_q.quo),
        .den_i (st_q.den),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            // A new operation always wins: it abandons any running divide.
            if (!op[1]) begin
                st_d.busy = 1'b0;
                st_d.hi   = prod[2*WIDTH-1:WIDTH];
                st_d.lo   = prod[WIDTH-1:0];
            end else if (opb == '0) begin
                st_d.busy = 1'b0;
                st_d.hi   = opa;
                st_d.lo   = a_neg ? ONE : ALL_ONES;
            end else if (op_e == OP_SDIV && opa == MIN_NEG && opb == ALL_ONES) begin
                st_d.busy = 1'b0;
                st_d.hi   = '0;
                st_d.lo   = MIN_NEG;
            end else begin
                st_d.busy  = 1'b1;
                st_d.cnt   = CW'(WIDTH);
                st_d.rem   = '0;
                st_d.quo   = a_mag;
                st_d.den   = b_mag;
                st_d.neg_q = a_neg ^ b_neg;
                st_d.neg_r = a_neg;
            end
        end else if (st_q.busy && st_q.cnt == '0) begin
            // Sign fix-up: the finishing divide overrides a same-cycle move.
            st_d.busy = 1'b0;
            st_d.lo   = st_q.neg_q ? (~st_q.quo + ONE) : st_q.quo;
            st_d.hi   = st_q.neg_r ? (~st_q.rem + ONE) : st_q.rem;
        end else begin
            if (st_q.busy) begin
                st_d.rem = step_rem;
                st_d.quo = step_quo;
                st_d.cnt = st_q.cnt - CW'(1);
            end
            if (hi_wr) st_d.hi = wr_data;
            if (lo_wr) st_d.lo = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign hi   = st_q.hi;
    assign lo   = st_q.lo;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       op,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             hi_wr,
    input logic             lo_wr,
    input logic [WIDTH-1:0] wr_data,
    input logic             busy,
    input logic [WIDTH-1:0] hi,
    input logic [WIDTH-1:0] lo
);
    localparam int              RC       = $clog2(WIDTH + 2) + 1;
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] MIN_NEG  = {1'b1, {(WIDTH-1){1'b0}}};

    logic [RC-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     run_cnt <= '0;
        else if (start) run_cnt <= '0;
        else if (busy)  run_cnt <= run_cnt + RC'(1);
    end

    AST_MUL_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start && !op[1] |=> !busy); // R1

    AST_SDIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start && op == 2'd2 && opb == '0 |=> !busy && hi == $past(opa)
            && lo == ($past(opa[WIDTH-1]) ? ONE : ALL_ONES)); // R5

    AST_UDIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start && op == 2'd3 && opb == '0 |=> !busy && hi == $past(opa) && lo == ALL_ONES); // R6

    AST_SDIV_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        start && op == 2'd2 && opa == MIN_NEG && opb == ALL_ONES |=> !busy && hi == '0 && lo == MIN_NEG); // R7

    AST_DIV_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        start && op[1] && opb != '0 && !(op == 2'd2 && opa == MIN_NEG && opb == ALL_ONES) |=> busy); // R8

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_cnt <= RC'(WIDTH)); // R8

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && busy && !$past(start) && !$past(hi_wr) && !$past(lo_wr)
            |-> hi == $past(hi) && lo == $past(lo)); // R8

    AST_MOVE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr && !start && !busy |=> hi == $past(wr_data)); // R10

    AST_MOVE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr && !start && !busy |=> lo == $past(wr_data)); // R10
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .opa     (opa),
    .opb     (opb),
    .hi_wr   (hi_wr),
    .lo_wr   (lo_wr),
    .wr_data (wr_data),
    .busy    (busy),
    .hi      (hi),
    .lo      (lo)
);

// File: tb/hilo_muldiv_test.sv
module hilo_muldiv_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;
    logic rst_n = 1'b0;

    logic       s_start = 0, s_hw = 0, s_lw = 0, s_busy;
    logic [1:0] s_op = 0;
    logic [4:0] s_a = 0, s_b = 0, s_wd = 0, s_hi, s_lo;

    logic        l_start = 0, l_hw = 0, l_lw = 0, l_busy;
    logic [1:0]  l_op = 0;
    logic [31:0] l_a = 0, l_b = 0, l_wd = 0, l_hi, l_lo;

    hilo_muldiv #(.WIDTH(5)) uut (
        .clk(clk), .rst_n(rst_n), .start(s_start), .op(s_op), .opa(s_a), .opb(s_b),
        .hi_wr(s_hw), .lo_wr(s_lw), .wr_data(s_wd), .busy(s_busy), .hi(s_hi), .lo(s_lo));

    hilo_muldiv #(.WIDTH(32)) uut32 (
        .clk(clk), .rst_n(rst_n), .start(l_start), .op(l_op), .opa(l_a), .opb(l_b),
        .hi_wr(l_hw), .lo_wr(l_lw), .wr_data(l_wd), .busy(l_busy), .hi(l_hi), .lo(l_lo));

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void ref_op(input int w, input logic [1:0] op,
                                   input logic [63:0] a, input logic [63:0] b,
                                   output logic [63:0] rh, output logic [63:0] rl);
        logic [63:0] mask, ua, ub, p;
        longint sa, sb, lmin;
        mask = (64'd1 << w) - 64'd1;
        ua = a & mask;
        ub = b & mask;
        sa = ua[w-1] ? longint'(ua) - (longint'(1) << w) : longint'(ua);
        sb = ub[w-1] ? longint'(ub) - (longint'(1) << w) : longint'(ub);
        lmin = -(longint'(1) << (w - 1));
        p = 64'd0;
        if (op == 2'd0) p = 64'(sa * sb);
        if (op == 2'd1) p = ua * ub;
        if (op < 2'd2) begin
            rh = (p >> w) & mask;
            rl = p & mask;
        end else if (op == 2'd2) begin
            if (sb == 0) begin
                rh = ua; rl = (sa < 0) ? 64'd1 : mask;
            end else if (sa == lmin && sb == -1) begin
                rh = 64'd0; rl = ua;
            end else begin
                rh = 64'(sa % sb) & mask;
                rl = 64'(sa / sb) & mask;
            end
        end else begin
            if (ub == 0) begin
                rh = ua; rl = mask;
            end else begin
                rh = ua % ub; rl = ua / ub;
            end
        end
    endfunction

    function automatic string req_of(input int w, input logic [1:0] op,
                                     input logic [63:0] a, input logic [63:0] b);
        logic [63:0] mask;
        mask = (64'd1 << w) - 64'd1;
        if (op == 2'd0) return "R1";
        if (op == 2'd1) return "R2";
        if ((b & mask) == 0) return (op == 2'd2) ? "R5" : "R6";
        if (op == 2'd2 && (a & mask) == (64'd1 << (w - 1)) && (b & mask) == mask) return "R7";
        return (op == 2'd2) ? "R3" : "R4";
    endfunction

    task automatic run_s(input logic [1:0] op, input logic [4:0] a, input logic [4:0] b);
        logic [63:0] eh, el;
        logic [4:0] h0, l0;
        int n;
        bit held;
        string r;
        ref_op(5, op, {59'd0, a}, {59'd0, b}, eh, el);
        r = req_of(5, op, {59'd0, a}, {59'd0, b});
        @(negedge clk);
        s_op = op; s_a = a; s_b = b; s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        n = 0; held = 1'b1; h0 = s_hi; l0 = s_lo;
        while (s_busy && n < 100) begin
            if (s_hi !== h0 || s_lo !== l0) held = 1'b0;
            n++;
            @(negedge clk);
        end
        chk({r, " hi"}, {59'd0, s_hi}, eh);
        chk({r, " lo"}, {59'd0, s_lo}, el);
        if (r == "R3" || r == "R4") begin
            chk("R8 busy length", 64'(n), 64'd6);
            chk("R8 hold while busy", {63'd0, held}, 64'd1);
        end else begin
            chk({r, " no busy"}, 64'(n), 64'd0);
        end
    endtask

    task automatic run_l(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] eh, el;
        int n;
        string r;
        ref_op(32, op, {32'd0, a}, {32'd0, b}, eh, el);
        r = req_of(32, op, {32'd0, a}, {32'd0, b});
        @(negedge clk);
        l_op = op; l_a = a; l_b = b; l_start = 1'b1;
        @(negedge clk);
        l_start = 1'b0;
        n = 0;
        while (l_busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk({r, " hi w32"}, {32'd0, l_hi}, eh);
        chk({r, " lo w32"}, {32'd0, l_lo}, el);
        chk({r, " busy w32"}, 64'(n), (r == "R3" || r == "R4") ? 64'd33 : 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired (R8 busy never fell)");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 hi", {59'd0, s_hi}, 64'd0);
        chk("R11 lo", {59'd0, s_lo}, 64'd0);
        chk("R11 busy", {63'd0, s_busy}, 64'd0);
        chk("R11 hi w32", {32'd0, l_hi}, 64'd0);
        chk("R11 busy w32", {63'd0, l_busy}, 64'd0);

        // Exhaustive sweep on the 5-bit instance: R1..R8
        for (int o = 0; o < 4; o++)
            for (int a = 0; a < 32; a++)
                for (int b = 0; b < 32; b++)
                    run_s(2'(o), 5'(a), 5'(b));

        // Directed 32-bit extremes
        run_l(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_l(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_l(2'd0, 32'h8000_0000, 32'h8000_0000);
        run_l(2'd0, 32'h8000_0000, 32'h0000_0003);
        run_l(2'd2, 32'hFFFF_FFF9, 32'd2);
        run_l(2'd2, 32'd7, 32'hFFFF_FFFE);
        run_l(2'd3, 32'hFFFF_FFFF, 32'd3);
        run_l(2'd2, 32'd12345, 32'd0);
        run_l(2'd2, 32'hFFFF_0000, 32'd0);
        run_l(2'd3, 32'h8000_0001, 32'd0);
        run_l(2'd2, 32'h8000_0000, 32'hFFFF_FFFF);
        run_l(2'd2, 32'h8000_0000, 32'd1);
        run_l(2'd2, 32'h8000_0000, 32'd2);
        run_l(2'd3, 32'h8000_0000, 32'hFFFF_FFFF);

        // R9: restart a divide with another divide
        @(negedge clk);
        l_op = 2'd2; l_a = 32'd100; l_b = 32'd7; l_start = 1'b1;
        @(negedge clk);
        l_start = 1'b0;
        repeat (5) @(negedge clk);
        l_op = 2'd3; l_a = 32'd1000; l_b = 32'd10; l_start = 1'b1;
        @(negedge clk);
        l_start = 1'b0;
        n = 0;
        while (l_busy && n < 100) begin n++; @(negedge clk); end
        chk("R9 restart busy", 64'(n), 64'd33);
        chk("R9 restart lo", {32'd0, l_lo}, 64'd100);
        chk("R9 restart hi", {32'd0, l_hi}, 64'd0);

        // R9: a multiply abandons a running divide
        @(negedge clk);
        l_op = 2'd2; l_a = 32'd999; l_b = 32'd4; l_start = 1'b1;
        @(negedge clk);
        l_start = 1'b0;
        repeat (3) @(negedge clk);
        l_op = 2'd1; l_a = 32'd6; l_b = 32'd7; l_start = 1'b1;
        @(negedge clk);
        l_start = 1'b0;
        chk("R9 mul abandon busy", {63'd0, l_busy}, 64'd0);
        repeat (40) @(negedge clk);
        chk("R9 mul abandon lo", {32'd0, l_lo}, 64'd42);
        chk("R9 mul abandon hi", {32'd0, l_hi}, 64'd0);

        // R10: move ports
        @(negedge clk);
        l_hw = 1'b1; l_wd = 32'hDEAD_BEEF;
        @(negedge clk);
        l_hw = 1'b0;
        chk("R10 move hi", {32'd0, l_hi}, 64'hDEAD_BEEF);
        chk("R10 lo untouched", {32'd0, l_lo}, 64'd42);
        l_lw = 1'b1; l_wd = 32'h1234_5678;
        @(negedge clk);
        l_lw = 1'b0;
        chk("R10 move lo", {32'd0, l_lo}, 64'h1234_5678);
        chk("R10 hi untouched", {32'd0, l_hi}, 64'hDEAD_BEEF);
        // R10: start has priority over a same-cycle move
        l_hw = 1'b1; l_lw = 1'b1; l_wd = 32'd5;
        l_op = 2'd1; l_a = 32'd3; l_b = 32'd3; l_start = 1'b1;
        @(negedge clk);
        l_hw = 1'b0; l_lw = 1'b0; l_start = 1'b0;
        chk("R10 start beats move lo", {32'd0, l_lo}, 64'd9);
        chk("R10 start beats move hi", {32'd0, l_hi}, 64'd0);
        // R10 on the small instance
        s_hw = 1'b1; s_wd = 5'h15;
        @(negedge clk);
        s_hw = 1'b0;
        chk("R10 move hi w5", {59'd0, s_hi}, 64'h15);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule